// File: doc/BRIEF.md
# Multi-Width Instruction Fetch Extractor

This block is the front end of a core's fetch path. The core runs in one of three instruction widths: full 32-bit words, 16-bit compressed halfwords, or 8-bit bytecodes. Instructions and data share a single 32-bit memory bus. The block reads one aligned word at a time and then hands out one, two or four instructions from that word, depending on the current width. It does not read again until every instruction in the word has been used. A branch target can be loaded at any time. A target that breaks the alignment rule for the current width parks the unit in a fault state and no read is issued. A memory wait input freezes all progress.

The controller has three named states. FETCH issues a read and captures the word. DRAIN issues one instruction per free cycle from the captured word. FAULT holds the alignment error.

The transitions are:
- FETCH→DRAIN when the read completes.
- DRAIN→DRAIN on an instruction that is not the last in the word.
- DRAIN→FETCH on the last instruction in the word.
- Any state→FETCH on an aligned redirect, or on a width change whose resume address is aligned.
- Any state→FAULT on a misaligned redirect, or on a width change that leaves the resume address misaligned.
- FAULT→FAULT until an aligned redirect arrives.

Top module: `fx_fetch_unit`

## Requirements
- R1: While reset is held and in the first free cycle after it, the unit is in FETCH in 32-bit width. It drives address 0 with `mem_seq_o` low, `insn_valid_o` low and `align_err_o` low.
- R2: In 32-bit width (`mode_i`=0, and the reserved code 3 behaves the same), each word read produces exactly one instruction equal to the whole word, and the address advances by 4.
- R3: In 16-bit width (`mode_i`=1), each read produces up to two instructions, zero-extended. Bits 15:0 are used at byte offset 0 and bits 31:16 at offset 2. No new read is issued until the last halfword of the word has been consumed.
- R4: In 8-bit width (`mode_i`=2), each read produces up to four zero-extended instructions. Bits 7:0 come first and bits 31:24 last. There is one read per word.
- R5: `mem_seq_o` is high on a read whose address is the previous read address plus 4. It is low on the first read after reset, after a redirect, and after a width change.
- R6: While `stall_i` is high, `mem_req_o` and `insn_valid_o` are low. The fetch address, width and state do not change, and redirects and width changes presented during the stall have no effect.
- R7: An aligned redirect discards the captured word. The next read is the word that contains the target, and the first instruction comes from the target's byte offset.
- R8: A redirect is misaligned in 32-bit width if target bits 1:0 are nonzero, and in 16-bit width if target bit 0 is set. A misaligned redirect raises `align_err_o` from the next cycle and issues no read and no instruction. This lasts until an aligned redirect arrives; 8-bit width never faults.
- R9: When `mode_i` differs from the held width in a free cycle, the captured word is discarded and the unit re-reads the word holding the next instruction address in the new width. If that address is misaligned for the new width, the unit enters FAULT instead.
- R10: `mem_addr_o` is always word aligned (bits 1:0 zero).
- R11: An instruction appears with `insn_valid_o` in the first free cycle after its read cycle. `insn_valid_o` is never high in a read cycle, nor in a cycle where a redirect or width change is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_i | input | 2 | Instruction width: 0 word, 1 halfword, 2 byte, 3 treated as word |
| stall_i | input | 1 | Memory wait; freezes all progress |
| redirect_i | input | 1 | Load a branch target this cycle |
| redirect_addr_i | input | 32 | Branch target byte address |
| mem_rdata_i | input | 32 | Read data returned in the read cycle |
| mem_req_o | output | 1 | Read request this cycle |
| mem_addr_o | output | 32 | Word-aligned read address |
| mem_seq_o | output | 1 | Read address follows the previous read |
| insn_o | output | 32 | Extracted instruction, zero-extended |
| insn_valid_o | output | 1 | `insn_o` is consumed this cycle |
| align_err_o | output | 1 | Misaligned target or resume address |

## Verification
The hardest situation to reach is a width change that lands in the middle of a word at an exact byte offset, for example switching from bytes to halfwords after an odd number of bytes. This must not consume one instruction more or less than intended. The stimulus reaches it by waiting for the scoreboard to pop the last expected instruction of a run and then applying the change at the very next clock edge, so the resume address is known exactly. It also masks the pseudo-random wait pattern for that one control cycle. The same technique places a misaligned resume address and a redirect held under a long wait, where the redirect must be ignored.

// File: rtl/fx_pkg.sv
package fx_pkg;

    typedef enum logic [1:0] {
        MODE_WORD = 2'd0,
        MODE_HALF = 2'd1,
        MODE_BYTE = 2'd2,
        MODE_RSVD = 2'd3
    } fx_mode_e;

    typedef enum logic [1:0] {
        ST_FETCH = 2'd0,
        ST_DRAIN = 2'd1,
        ST_FAULT = 2'd2
    } fx_state_e;

endpackage

// File: rtl/fx_align_chk.sv
module fx_align_chk
    import fx_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int OFF_W = $clog2(DATA_W / 8)
) (
    input  fx_mode_e         mode,
    input  logic [OFF_W-1:0] addr_lo,
    output logic             misaligned
);

    always_comb begin
        unique case (mode)
            MODE_HALF: misaligned = addr_lo[0];
            MODE_BYTE: misaligned = 1'b0;
            default:   misaligned = |addr_lo;
        endcase
    end

endmodule

// File: rtl/fx_lane_sel.sv
module fx_lane_sel
    import fx_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int NB    = DATA_W / 8,
    localparam int NH    = NB / 2,
    localparam int OFF_W = $clog2(NB)
) (
    input  logic [DATA_W-1:0] word,
    input  logic [OFF_W-1:0]  off,
    input  fx_mode_e          mode,
    output logic [DATA_W-1:0] insn
);

    logic [7:0]  byte_lane [NB];
    logic [15:0] half_lane [NH];

    for (genvar b = 0; b < NB; b++) begin : g_byte
        assign byte_lane[b] = word[8*b +: 8];
    end

    for (genvar h = 0; h < NH; h++) begin : g_half
        assign half_lane[h] = word[16*h +: 16];
    end

    always_comb begin
        unique case (mode)
            MODE_HALF: insn = DATA_W'(half_lane[off[OFF_W-1:1]]);
            MODE_BYTE: insn = DATA_W'(byte_lane[off]);
            default:   insn = word;
        endcase
    end

endmodule

// File: rtl/fx_ctrl.sv
module fx_ctrl
    import fx_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    localparam int NB    = DATA_W / 8,
    localparam int OFF_W = $clog2(NB)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  fx_mode_e          mode_in,
    input  logic              stall_i,
    input  logic              redirect_i,
    input  logic [ADDR_W-1:0] redirect_addr_i,
    input  logic [DATA_W-1:0] mem_rdata_i,
    output logic              mem_req_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic              mem_seq_o,
    output logic [DATA_W-1:0] word_o,
    output logic [OFF_W-1:0]  off_o,
    output fx_mode_e          mode_o,
    output logic              insn_valid_o,
    output logic              align_err_o
);

    fx_state_e         state_q, state_d;
    logic [ADDR_W-1:0] pc_q, pc_d;
    logic              seq_q, seq_d;
    fx_mode_e          mode_q, mode_d;
    logic [DATA_W-1:0] word_q, word_d;

    logic              go, mode_chg, redir_mis, pc_mis, lane_last;
    logic [OFF_W:0]    step, off_sum;

    fx_align_chk #(.DATA_W(DATA_W)) u_chk_redir (
        .mode       (mode_in),
        .addr_lo    (redirect_addr_i[OFF_W-1:0]),
        .misaligned (redir_mis)
    );

    fx_align_chk #(.DATA_W(DATA_W)) u_chk_pc (
        .mode       (mode_in),
        .addr_lo    (pc_q[OFF_W-1:0]),
        .misaligned (pc_mis)
    );

    assign go       = !stall_i;
    assign mode_chg = (mode_in != mode_q);

    always_comb begin
        unique case (mode_q)
            MODE_HALF: step = (OFF_W+1)'(2);
            MODE_BYTE: step = (OFF_W+1)'(1);
            default:   step = (OFF_W+1)'(NB);
        endcase
        off_sum   = {1'b0, pc_q[OFF_W-1:0]} + step;
        lane_last = off_sum[OFF_W];
    end

    // next-state and datapath updates
    always_comb begin
        state_d = state_q;
        pc_d    = pc_q;
        seq_d   = seq_q;
        mode_d  = mode_q;
        word_d  = word_q;
        if (go && redirect_i) begin
            mode_d = mode_in;
            seq_d  = 1'b0;
            if (redir_mis) begin
                state_d = ST_FAULT;
            end else begin
                pc_d    = redirect_addr_i;
                state_d = ST_FETCH;
            end
        end else if (go && mode_chg) begin
            mode_d = mode_in;
            seq_d  = 1'b0;
            if (state_q == ST_FAULT || pc_mis) state_d = ST_FAULT;
            else                               state_d = ST_FETCH;
        end else if (go) begin
            unique case (state_q)
                ST_FETCH: begin
                    word_d  = mem_rdata_i;
                    seq_d   = 1'b1;
                    state_d = ST_DRAIN;
                end
                ST_DRAIN: begin
                    pc_d = pc_q + ADDR_W'(step);
                    if (lane_last) state_d = ST_FETCH;
                end
                ST_FAULT: state_d = ST_FAULT;
                default:  state_d = ST_FETCH;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_FETCH;
            pc_q    <= '0;
            seq_q   <= 1'b0;
            mode_q  <= MODE_WORD;
            word_q  <= '0;
        end else begin
            state_q <= state_d;
            pc_q    <= pc_d;
            seq_q   <= seq_d;
            mode_q  <= mode_d;
            word_q  <= word_d;
        end
    end

    // outputs
    always_comb begin
        mem_req_o    = 1'b0;
        insn_valid_o = 1'b0;
        align_err_o  = 1'b0;
        unique case (state_q)
            ST_FETCH: mem_req_o    = go && !redirect_i && !mode_chg;
            ST_DRAIN: insn_valid_o = go && !redirect_i && !mode_chg;
            ST_FAULT: align_err_o  = 1'b1;
            default:  ;
        endcase
        mem_addr_o = {pc_q[ADDR_W-1:OFF_W], OFF_W'(0)};
        mem_seq_o  = mem_req_o && seq_q;
        word_o     = word_q;
        off_o      = pc_q[OFF_W-1:0];
        mode_o     = mode_q;
    end

    // ---------------- assertions ----------------
    logic [ADDR_W-1:0] last_rd_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         last_rd_q <= '0;
        else if (mem_req_o) last_rd_q <= mem_addr_o;
    end

    p_seq_addr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && mem_seq_o) |-> (mem_addr_o == last_rd_q + ADDR_W'(NB)));

    p_stall_freeze_r6: assert property (@(posedge clk) disable iff (!rst_n)
        stall_i |=> ($stable(pc_q) && $stable(state_q) && $stable(mode_q)));

    p_misalign_fault_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (go && redirect_i && redir_mis) |=> align_err_o);

    p_fault_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        align_err_o |-> (!mem_req_o && !insn_valid_o));

    p_hold_word_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (insn_valid_o && !lane_last) |=> !mem_req_o);

    p_read_to_drain_r11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o |=> (state_q == ST_DRAIN));

endmodule

// File: rtl/fx_fetch_unit.sv
module fx_fetch_unit
    import fx_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    localparam int NB    = DATA_W / 8,
    localparam int OFF_W = $clog2(NB)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode_i,
    input  logic              stall_i,
    input  logic              redirect_i,
    input  logic [ADDR_W-1:0] redirect_addr_i,
    input  logic [DATA_W-1:0] mem_rdata_i,
    output logic              mem_req_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic              mem_seq_o,
    output logic [DATA_W-1:0] insn_o,
    output logic              insn_valid_o,
    output logic              align_err_o
);

    fx_mode_e          mode_held;
    logic [DATA_W-1:0] word_buf;
    logic [OFF_W-1:0]  word_off;

    fx_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
        .clk             (clk),
        .rst_n           (rst_n),
        .mode_in         (fx_mode_e'(mode_i)),
        .stall_i         (stall_i),
        .redirect_i      (redirect_i),
        .redirect_addr_i (redirect_addr_i),
        .mem_rdata_i     (mem_rdata_i),
        .mem_req_o       (mem_req_o),
        .mem_addr_o      (mem_addr_o),
        .mem_seq_o       (mem_seq_o),
        .word_o          (word_buf),
        .off_o           (word_off),
        .mode_o          (mode_held),
        .insn_valid_o    (insn_valid_o),
        .align_err_o     (align_err_o)
    );

    fx_lane_sel #(.DATA_W(DATA_W)) u_lane (
        .word (word_buf),
        .off  (word_off),
        .mode (mode_held),
        .insn (insn_o)
    );

    p_addr_word_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o |-> (mem_addr_o[OFF_W-1:0] == '0));

endmodule

// File: tb/tb_fx_fetch_unit.sv
`timescale 1ns/1ps
module tb_fx_fetch_unit;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [1:0]  mode_i;
    logic        stall_i;
    logic        redirect_i;
    logic [31:0] redirect_addr_i;
    logic [31:0] mem_rdata_i;
    logic        mem_req_o;
    logic [31:0] mem_addr_o;
    logic        mem_seq_o;
    logic [31:0] insn_o;
    logic        insn_valid_o;
    logic        align_err_o;

    always #2.5 clk = ~clk;

    fx_fetch_unit dut (
        .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .stall_i(stall_i),
        .redirect_i(redirect_i), .redirect_addr_i(redirect_addr_i),
        .mem_rdata_i(mem_rdata_i), .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o),
        .mem_seq_o(mem_seq_o), .insn_o(insn_o), .insn_valid_o(insn_valid_o),
        .align_err_o(align_err_o)
    );

    int nchk = 0;
    int nerr = 0;

    function automatic logic [31:0] memw(input logic [31:0] a);
        logic [7:0] i;
        i = a[9:2];
        return {~i, i ^ 8'hA5, i ^ 8'h5A, i};
    endfunction

    assign mem_rdata_i = memw(mem_addr_o);

    function automatic logic [31:0] exp_insn(input logic [1:0] m, input logic [31:0] a);
        logic [31:0] w;
        w = memw({a[31:2], 2'b00});
        case (m)
            2'd1:    return {16'h0, w[16*a[1] +: 16]};
            2'd2:    return {24'h0, w[8*a[1:0] +: 8]};
            default: return w;
        endcase
    endfunction

    function automatic int step_of(input logic [1:0] m);
        return (m == 2'd1) ? 2 : (m == 2'd2) ? 1 : 4;
    endfunction

    task automatic chk(input bit ok, input string msg, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s: act=%0h exp=%0h", msg, act, exp);
        end
    endtask

    // scoreboard queues
    logic [31:0] iq[$];
    string       it[$];
    logic [32:0] rq[$];
    string       rt[$];
    logic        iq_empty = 1'b1;

    task automatic push_run(input logic [1:0] m, input logic [31:0] p, input int n,
                            input bit first_seq, input string tag);
        logic [31:0] pc;
        logic [31:0] last_w;
        bit          first;
        pc = p; first = 1'b1; last_w = 32'hFFFF_FFFF;
        for (int k = 0; k < n; k++) begin
            if (first || ({pc[31:2], 2'b00} != last_w)) begin
                rq.push_back({first ? first_seq : 1'b1, pc[31:2], 2'b00});
                rt.push_back(tag);
                last_w = {pc[31:2], 2'b00};
                first = 1'b0;
            end
            iq.push_back(exp_insn(m, pc));
            it.push_back(tag);
            pc += step_of(m);
        end
        if (n > 0) iq_empty = 1'b0;
    endtask

    // monitor
    always @(negedge clk) begin : mon
        logic [32:0] r;
        logic [31:0] e;
        string       t;
        if (rst_n) begin
            if (mem_req_o && rq.size() > 0) begin
                r = rq.pop_front();
                t = rt.pop_front();
                chk(mem_addr_o == r[31:0], {t, " R10 read address"}, 64'(mem_addr_o), 64'(r[31:0]));
                chk(mem_seq_o == r[32], {t, " R5 sequential hint"}, 64'(mem_seq_o), 64'(r[32]));
            end
            if (insn_valid_o && iq.size() > 0) begin
                e = iq.pop_front();
                t = it.pop_front();
                chk(insn_o == e, {t, " instruction"}, 64'(insn_o), 64'(e));
                if (iq.size() == 0) iq_empty = 1'b1;
            end
        end
    end

    // wait generator
    logic [31:0] cyc = 0;
    logic        stall_pat_en = 1'b0;
    logic        force_stall = 1'b0;
    logic        ctl_hold = 1'b0;
    always @(posedge clk) cyc <= cyc + 1;
    assign stall_i = force_stall |
        (stall_pat_en & ~ctl_hold & (((cyc % 5) == 2) || ((cyc % 7) == 4)));

    task automatic ctl_redirect(input logic [1:0] m, input logic [31:0] a);
        @(posedge clk); #1;
        ctl_hold = 1'b1; mode_i = m; redirect_i = 1'b1; redirect_addr_i = a;
        @(posedge clk); #1;
        redirect_i = 1'b0; ctl_hold = 1'b0;
    endtask

    task automatic ctl_mode(input logic [1:0] m);
        @(posedge clk); #1;
        ctl_hold = 1'b1; mode_i = m;
        @(posedge clk); #1;
        ctl_hold = 1'b0;
    endtask

    task automatic drain(input string tag);
        wait (iq_empty);
        chk(rq.size() == 0, {tag, " all expected reads seen"}, 64'(rq.size()), 64'd0);
    endtask

    task automatic fault_hold(input string tag);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk(align_err_o == 1'b1, {tag, " align_err_o high"}, 64'(align_err_o), 64'd1);
            chk(!mem_req_o && !insn_valid_o, {tag, " no read or instruction in fault"},
                64'({mem_req_o, insn_valid_o}), 64'd0);
        end
    endtask

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        nchk++; nerr++;
        $display("FAIL watchdog: act=expired exp=finished");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        rst_n = 1'b0; mode_i = 2'd0; redirect_i = 1'b0; redirect_addr_i = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(mem_addr_o == 32'h0, "R1 reset address", 64'(mem_addr_o), 64'd0);
        chk(mem_req_o && !mem_seq_o, "R1 reset read, not sequential", 64'({mem_req_o, mem_seq_o}), 64'b10);
        chk(!insn_valid_o && !align_err_o, "R1 reset no valid, no error",
            64'({insn_valid_o, align_err_o}), 64'd0);
        push_run(2'd0, 32'h0, 5, 1'b0, "R1");
        @(posedge clk); #1; rst_n = 1'b1;
        drain("R1");

        // R11 exact timing, no waits
        @(posedge clk); #1; redirect_i = 1'b1; redirect_addr_i = 32'h40;
        @(negedge clk);
        chk(!mem_req_o && !insn_valid_o, "R11 quiet in redirect cycle", 64'({mem_req_o, insn_valid_o}), 64'd0);
        @(posedge clk); #1; redirect_i = 1'b0;
        @(negedge clk);
        chk(mem_req_o && mem_addr_o == 32'h40, "R7 read of target word", 64'(mem_addr_o), 64'h40);
        chk(!mem_seq_o, "R5 no hint after redirect", 64'(mem_seq_o), 64'd0);
        chk(!insn_valid_o, "R11 no valid in read cycle", 64'(insn_valid_o), 64'd0);
        @(negedge clk);
        chk(insn_valid_o && insn_o == memw(32'h40), "R11 instruction one cycle after read",
            64'(insn_o), 64'(memw(32'h40)));
        @(negedge clk);
        chk(mem_req_o && mem_addr_o == 32'h44 && mem_seq_o, "R5 hint on next word",
            64'({mem_seq_o, mem_addr_o}), 64'({1'b1, 32'h44}));

        stall_pat_en = 1'b1;
        ctl_redirect(2'd0, 32'h100);
        push_run(2'd0, 32'h100, 6, 1'b0, "R2");
        drain("R2");

        ctl_mode(2'd1);
        push_run(2'd1, 32'h118, 7, 1'b0, "R9");
        drain("R9");

        ctl_redirect(2'd1, 32'h202);
        push_run(2'd1, 32'h202, 7, 1'b0, "R3");
        drain("R3");

        ctl_mode(2'd2);
        push_run(2'd2, 32'h210, 9, 1'b0, "R4");
        drain("R4");

        ctl_redirect(2'd2, 32'h303);
        push_run(2'd2, 32'h303, 6, 1'b0, "R7");
        drain("R7");

        // byte to halfword at odd resume address
        ctl_mode(2'd1);
        fault_hold("R9");

        ctl_redirect(2'd1, 32'h400);
        push_run(2'd1, 32'h400, 4, 1'b0, "R8");
        drain("R8");
        chk(!align_err_o, "R8 error cleared by aligned redirect", 64'(align_err_o), 64'd0);

        ctl_mode(2'd3);
        push_run(2'd0, 32'h408, 2, 1'b0, "R2");
        drain("R2");

        ctl_redirect(2'd0, 32'h102);
        fault_hold("R8");

        ctl_redirect(2'd2, 32'h503);
        push_run(2'd2, 32'h503, 5, 1'b0, "R8");
        drain("R8");

        ctl_redirect(2'd1, 32'h101);
        fault_hold("R8");

        ctl_redirect(2'd0, 32'h600);
        push_run(2'd0, 32'h600, 3, 1'b0, "R8");
        drain("R8");

        // R6: long wait with redirect and width change presented underneath
        @(posedge clk); #1;
        stall_pat_en = 1'b0; force_stall = 1'b1;
        push_run(2'd0, 32'h60C, 3, 1'b1, "R6");
        for (int k = 0; k < 4; k++) begin
            if (k == 1) begin
                @(posedge clk); #1;
                redirect_i = 1'b1; redirect_addr_i = 32'h102; mode_i = 2'd2;
            end
            @(negedge clk);
            chk(!mem_req_o && !insn_valid_o, "R6 quiet during wait", 64'({mem_req_o, insn_valid_o}), 64'd0);
            chk(!align_err_o, "R6 redirect ignored during wait", 64'(align_err_o), 64'd0);
        end
        @(posedge clk); #1;
        force_stall = 1'b0; redirect_i = 1'b0; mode_i = 2'd0;
        drain("R6");
        chk(!align_err_o, "R6 no fault after wait", 64'(align_err_o), 64'd0);

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule